// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This controller turns four mode-control bits into the enables for a CPU core, a main clock, a sub-main clock, an auxiliary clock, the digitally controlled oscillator (DCO) and the DC generator that biases that oscillator. It also enables a crystal oscillator. The bits select active mode or one of five low-power modes. Software writes the bits while the CPU runs. Writing a low-power pattern halts the CPU until an interrupt arrives.

When an interrupt is accepted, the current bits go into a saved copy. The oscillator-off, sub-main-gate and CPU-off bits are then cleared, so the handler runs with the CPU and clocks up. A return strobe reloads the saved copy. While the handler runs it may rewrite the saved copy, so the return can resume a different mode from the one that was interrupted.

The three clock outputs come from the free-running sources through gate flops. Each gate flop is clocked on the falling edge of its own source, so switching a clock on or off never produces a shortened pulse.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: Mode bit positions are [3] sub-main gate 1, [2] sub-main gate 0, [1] oscillator off, [0] CPU off. When all bits are 0, every enable is 1: cpu, mclk, smclk, aclk, dco_osc, dco_gen, xtal.
- R2: Pattern 4'b0001 sets cpu_en and mclk_en to 0, while smclk_en, aclk_en, dco_osc_en, dco_gen_en and xtal_en stay 1.
- R3: Pattern 4'b0101 gives the same enables as R2, except that dco_gen_en is 0 when dco_feeds_main and dco_feeds_sub are both 0.
- R4: Pattern 4'b1001 sets cpu_en, mclk_en, smclk_en and dco_osc_en to 0, while aclk_en, dco_gen_en and xtal_en stay 1.
- R5: Pattern 4'b1101 leaves only aclk_en and xtal_en at 1.
- R6: Any pattern with bits [1] and [0] both set drives every enable to 0, whatever bits [3:2] hold.
- R7: An accepted interrupt copies mode_bits into saved_bits and clears bits [3], [1] and [0] while keeping bit [2]. It sets in_handler. All of this takes effect one clock after the request is sampled.
- R8: An interrupt request is ignored while in_handler is 1. It is also ignored while bit [1] is set, unless irq_external is 1.
- R9: A return strobe while in_handler is 1 loads saved_bits into mode_bits and clears in_handler. A return strobe outside a handler has no effect.
- R10: saved_wr writes saved_wdata into the saved copy only while in_handler is 1, so the next return resumes the written mode. Outside a handler the write is ignored.
- R11: mode_wr loads mode_wdata only while bit [0] is 0. If a request is accepted in the same cycle, the interrupt takes priority and the write is dropped.
- R12: A gated clock output rises and falls only together with its source, so it never shows a shortened pulse. It stays low while its enable is 0.
- R13: Reset sets mode_bits and saved_bits to 0 and clears in_handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_src | input | 1 | Free-running main clock source |
| smclk_src | input | 1 | Free-running sub-main clock source |
| aclk_src | input | 1 | Free-running auxiliary clock source |
| dco_feeds_main | input | 1 | DCO drives the main clock |
| dco_feeds_sub | input | 1 | DCO drives the sub-main clock |
| mode_wr | input | 1 | Software write strobe for the mode bits |
| mode_wdata | input | 4 | Mode bits to write |
| irq_req | input | 1 | Interrupt request |
| irq_external | input | 1 | Request comes from an external source |
| ret_strobe | input | 1 | Return from interrupt |
| saved_wr | input | 1 | Write strobe for the saved copy |
| saved_wdata | input | 4 | Value for the saved copy |
| mode_bits | output | 4 | Current mode bits |
| saved_bits | output | 4 | Saved copy of the mode bits |
| in_handler | output | 1 | An interrupt is being serviced |
| cpu_en | output | 1 | CPU enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dco_osc_en | output | 1 | DCO enable |
| dco_gen_en | output | 1 | DCO DC generator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| mclk_out | output | 1 | Gated main clock |
| smclk_out | output | 1 | Gated sub-main clock |
| aclk_out | output | 1 | Gated auxiliary clock |

## Verification
The hardest state to reach is a return that lands in a mode different from the interrupted one. Reaching it takes a chain of steps. The bench writes a low-power pattern while the CPU runs, and wakes the block with an external request. Inside the handler it rewrites the saved copy, then issues the return. Only after those steps can it confirm the resumed mode and the gated clocks that follow it. The lowest mode needs a further step: internal requests are sent while it is held, to show that they cannot wake it before an external request does.

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl #(
  parameter int MODE_W = 4,
  parameter int NCLK   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclk_src,
  input  logic              smclk_src,
  input  logic              aclk_src,
  input  logic              dco_feeds_main,
  input  logic              dco_feeds_sub,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              irq_req,
  input  logic              irq_external,
  input  logic              ret_strobe,
  input  logic              saved_wr,
  input  logic [MODE_W-1:0] saved_wdata,
  output logic [MODE_W-1:0] mode_bits,
  output logic [MODE_W-1:0] saved_bits,
  output logic              in_handler,
  output logic              cpu_en,
  output logic              mclk_en,
  output logic              smclk_en,
  output logic              aclk_en,
  output logic              dco_osc_en,
  output logic              dco_gen_en,
  output logic              xtal_en,
  output logic              mclk_out,
  output logic              smclk_out,
  output logic              aclk_out
);
  localparam int B_CPU  = 0;
  localparam int B_OSC  = 1;
  localparam int B_SG0  = 2;
  localparam int B_SG1  = 3;
  localparam logic [MODE_W-1:0] KEEP_ON_IRQ = MODE_W'(1) << B_SG0;

  logic [MODE_W-1:0] mode_q, saved_q;
  logic              inh_q;

  wire cpu_off = mode_q[B_CPU];
  wire osc_off = mode_q[B_OSC];
  wire sg0     = mode_q[B_SG0];
  wire sg1     = mode_q[B_SG1];

  wire wake_ok  = ~osc_off | irq_external;
  wire take_irq = irq_req & ~inh_q & wake_ok;
  wire do_ret   = ret_strobe & inh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      saved_q <= '0;
      inh_q   <= 1'b0;
    end else if (take_irq) begin
      saved_q <= mode_q;
      mode_q  <= mode_q & KEEP_ON_IRQ;
      inh_q   <= 1'b1;
    end else if (do_ret) begin
      mode_q  <= saved_q;
      inh_q   <= 1'b0;
    end else begin
      if (mode_wr && !cpu_off) mode_q <= mode_wdata;
      if (saved_wr && inh_q) saved_q <= saved_wdata;
    end
  end

  wire all_off = osc_off & cpu_off;

  assign cpu_en     = ~cpu_off;
  assign mclk_en    = ~cpu_off;
  assign smclk_en   = ~sg1 & ~osc_off;
  assign aclk_en    = ~osc_off;
  assign xtal_en    = ~osc_off;
  assign dco_osc_en = ~osc_off & (~sg1 | (~cpu_off & dco_feeds_main));
  assign dco_gen_en = ~osc_off & ~all_off &
                      (~sg0 | (~sg1 & (dco_feeds_main | dco_feeds_sub)));

  assign mode_bits  = mode_q;
  assign saved_bits = saved_q;
  assign in_handler = inh_q;

  logic [NCLK-1:0] src, en, gate;
  assign src = {aclk_src, smclk_src, mclk_src};
  assign en  = {aclk_en, smclk_en, mclk_en};

  for (genvar g = 0; g < NCLK; g++) begin : g_gate
    always_ff @(negedge src[g] or negedge rst_n) begin
      if (!rst_n) gate[g] <= 1'b1;
      else        gate[g] <= en[g];
    end
  end

  assign mclk_out  = src[0] & gate[0];
  assign smclk_out = src[1] & gate[1];
  assign aclk_out  = src[2] & gate[2];
endmodule

module lpm_clock_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic       irq_external,
  input logic       ret_strobe,
  input logic [3:0] mode_bits,
  input logic [3:0] saved_bits,
  input logic       in_handler,
  input logic       cpu_en,
  input logic       mclk_en,
  input logic       smclk_en,
  input logic       aclk_en,
  input logic       dco_osc_en,
  input logic       dco_gen_en,
  input logic       xtal_en
);
  // R2
  lpm0_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits == 4'b0001) |-> (!cpu_en && !mclk_en && smclk_en && aclk_en && xtal_en));

  // R6
  lpm4_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[1] && mode_bits[0]) |->
      !(cpu_en || mclk_en || smclk_en || aclk_en || dco_osc_en || dco_gen_en || xtal_en));

  // R7
  irq_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !in_handler && (!mode_bits[1] || irq_external)) |=>
      (in_handler && saved_bits == $past(mode_bits) &&
       mode_bits == ($past(mode_bits) & 4'b0100)));

  // R8
  lpm4_internal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_external && mode_bits[1] && mode_bits[0] && !in_handler && !ret_strobe)
      |=> ($stable(mode_bits) && !in_handler));

  // R9
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && in_handler) |=> (!in_handler && mode_bits == $past(saved_bits)));

  // R11
  asleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_bits[0] && !irq_req && !ret_strobe) |=> $stable(mode_bits));
endmodule

bind lpm_clock_ctrl lpm_clock_ctrl_chk u_chk (.*);

// File: tb/lpm_clock_ctrl_bench.sv
module lpm_clock_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mclk_src = 1'b0, smclk_src = 1'b0, aclk_src = 1'b0;
  logic dco_feeds_main = 1'b1, dco_feeds_sub = 1'b1;
  logic mode_wr = 1'b0, irq_req = 1'b0, irq_external = 1'b0;
  logic ret_strobe = 1'b0, saved_wr = 1'b0;
  logic [3:0] mode_wdata = '0, saved_wdata = '0;
  logic [3:0] mode_bits, saved_bits;
  logic in_handler, cpu_en, mclk_en, smclk_en, aclk_en, dco_osc_en, dco_gen_en, xtal_en;
  logic mclk_out, smclk_out, aclk_out;

  int tests = 0, fails = 0, glitches = 0;
  int m_cnt = 0, s_cnt = 0, a_cnt = 0;
  bit finished = 0;

  always #2  clk = ~clk;
  always #2  mclk_src = ~mclk_src;
  always #4  smclk_src = ~smclk_src;
  always #16 aclk_src = ~aclk_src;

  lpm_clock_ctrl u_lpm_clock_ctrl (.*);

  always @(posedge mclk_out)  m_cnt++;
  always @(posedge smclk_out) s_cnt++;
  always @(posedge aclk_out)  a_cnt++;
  always @(posedge mclk_out)  if (!mclk_src)  glitches++;
  always @(negedge mclk_out)  if (mclk_src)   glitches++;
  always @(posedge smclk_out) if (!smclk_src) glitches++;
  always @(negedge smclk_out) if (smclk_src)  glitches++;
  always @(posedge aclk_out)  if (!aclk_src)  glitches++;
  always @(negedge aclk_out)  if (aclk_src)   glitches++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] en_vec();
    return {cpu_en, mclk_en, smclk_en, aclk_en, dco_osc_en, dco_gen_en, xtal_en};
  endfunction

  task automatic chk_en(input logic [6:0] exp, input string req);
    chk(en_vec() == exp, req, en_vec(), exp);
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic irq_pulse(input bit ext);
    @(negedge clk); irq_req = 1'b1; irq_external = ext;
    @(negedge clk); irq_req = 1'b0; irq_external = 1'b0;
  endtask

  task automatic edit_saved(input logic [3:0] m);
    @(negedge clk); saved_wr = 1'b1; saved_wdata = m;
    @(negedge clk); saved_wr = 1'b0;
  endtask

  task automatic ret_pulse();
    @(negedge clk); ret_strobe = 1'b1;
    @(negedge clk); ret_strobe = 1'b0;
  endtask

  task automatic go_active();
    irq_pulse(1'b1);
    edit_saved(4'b0000);
    ret_pulse();
  endtask

  task automatic t_reset();
    chk(mode_bits == 4'b0000, "R13 mode", mode_bits, 0);
    chk(saved_bits == 4'b0000, "R13 saved", saved_bits, 0);
    chk(in_handler == 1'b0, "R13 in_handler", in_handler, 0);
    chk_en(7'b1111111, "R1 active enables");
  endtask

  task automatic t_decode();
    write_mode(4'b0001); chk_en(7'b0011111, "R2 lpm0");
    go_active();
    dco_feeds_main = 1'b1; dco_feeds_sub = 1'b0;
    write_mode(4'b0101); chk_en(7'b0011111, "R3 lpm1 dco used");
    dco_feeds_main = 1'b0; @(negedge clk);
    chk_en(7'b0011101, "R3 lpm1 dco unused");
    dco_feeds_main = 1'b1; dco_feeds_sub = 1'b1;
    go_active();
    write_mode(4'b1001); chk_en(7'b0001011, "R4 lpm2");
    go_active();
    write_mode(4'b1101); chk_en(7'b0001001, "R5 lpm3");
    go_active();
    write_mode(4'b1111); chk_en(7'b0000000, "R6 lpm4 sg set");
    go_active();
    write_mode(4'b0011); chk_en(7'b0000000, "R6 lpm4 sg clear");
    go_active();
    chk_en(7'b1111111, "R1 back to active");
  endtask

  task automatic t_irq_return();
    write_mode(4'b1101);
    irq_pulse(1'b0);
    chk(saved_bits == 4'b1101, "R7 saved", saved_bits, 4'b1101);
    chk(mode_bits == 4'b0100, "R7 cleared", mode_bits, 4'b0100);
    chk(in_handler == 1'b1, "R7 in_handler", in_handler, 1);
    irq_pulse(1'b1);
    chk(saved_bits == 4'b1101, "R8 nested ignored", saved_bits, 4'b1101);
    ret_pulse();
    chk(mode_bits == 4'b1101, "R9 restored", mode_bits, 4'b1101);
    chk(in_handler == 1'b0, "R9 handler left", in_handler, 0);
    irq_pulse(1'b0);
    edit_saved(4'b0001);
    chk(saved_bits == 4'b0001, "R10 edited", saved_bits, 4'b0001);
    ret_pulse();
    chk(mode_bits == 4'b0001, "R10 resumes edited", mode_bits, 4'b0001);
    go_active();
  endtask

  task automatic t_ignored();
    ret_pulse();
    chk(mode_bits == 4'b0000 && !in_handler, "R9 stray return", mode_bits, 0);
    edit_saved(4'b1010);
    chk(saved_bits == 4'b0000, "R10 write outside handler", saved_bits, 0);
    write_mode(4'b0001);
    write_mode(4'b0000);
    chk(mode_bits == 4'b0001, "R11 write while asleep", mode_bits, 4'b0001);
    go_active();
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 4'b1101; irq_req = 1'b1;
    @(negedge clk); mode_wr = 1'b0; irq_req = 1'b0;
    chk(mode_bits == 4'b0000 && in_handler, "R11 irq wins", mode_bits, 0);
    chk(saved_bits == 4'b0000, "R11 saved pre-write", saved_bits, 0);
    ret_pulse();
    write_mode(4'b0011);
    for (int i = 0; i < 3; i++) irq_pulse(1'b0);
    chk(mode_bits == 4'b0011 && !in_handler, "R8 internal in lpm4", mode_bits, 4'b0011);
    irq_pulse(1'b1);
    chk(mode_bits == 4'b0000 && in_handler, "R8 external wakes", mode_bits, 0);
    chk(saved_bits == 4'b0011, "R7 lpm4 saved", saved_bits, 4'b0011);
    edit_saved(4'b0000);
    ret_pulse();
  endtask

  task automatic count_window(output int dm, output int ds, output int da);
    int m0, s0, a0;
    repeat (20) @(negedge clk);
    m0 = m_cnt; s0 = s_cnt; a0 = a_cnt;
    repeat (40) @(negedge clk);
    dm = m_cnt - m0; ds = s_cnt - s0; da = a_cnt - a0;
  endtask

  task automatic t_gating();
    int dm, ds, da;
    count_window(dm, ds, da);
    chk(dm == 40 && ds == 20 && da == 5, "R12 active clocks", dm, 40);
    write_mode(4'b0001);
    count_window(dm, ds, da);
    chk(dm == 0 && ds == 20, "R12 lpm0 main stopped", dm, 0);
    go_active();
    write_mode(4'b1101);
    count_window(dm, ds, da);
    chk(ds == 0 && da == 5, "R12 lpm3 aux only", ds, 0);
    go_active();
    write_mode(4'b0011);
    count_window(dm, ds, da);
    chk(dm == 0 && ds == 0 && da == 0, "R12 lpm4 silent", da, 0);
    go_active();
    count_window(dm, ds, da);
    chk(dm == 40 && da == 5, "R12 clocks resume", dm, 40);
    chk(glitches == 0, "R12 no runt pulse", glitches, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_irq_return();
    t_ignored();
    t_gating();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule